// File: doc/BRIEF.md
# Serial Receiver with Mute Wake-Up

This block receives asynchronous serial words from one RX line. The line is sampled on a strobe that runs at sixteen times the bit rate. A received word is placed in a data register, and a set of flags reports its status. The frame is a low start bit, then eight or nine data bits sent least significant bit first, then a high stop bit. In nine-bit mode the extra bit is kept in a separate status output.

A mute control lets a node on a shared line ignore traffic that is addressed to other nodes. While the block is muted, completed words change neither the data register nor any flag. Hardware leaves mute mode when it sees the wake-up condition chosen by a control input. That condition is either a quiet line lasting one frame time, or a word whose top data bit is set. A single interrupt request combines the receive events and the idle event, each group gated by its own enable.

Top module: `rxMuteReceiver`

## Requirements
- R1: With `wordLen9`=0 a frame is one start bit, 8 data bits (LSB first) and one stop bit. On completion `rxData` holds the 8 bits and `rxFull` goes to 1.
- R2: With `wordLen9`=1 the frame carries 9 data bits. The lower 8 go to `rxData` and the ninth goes to `rxBit8`. In 8-bit mode `rxBit8` is loaded with 0.
- R3: Each bit is decided by majority vote over the line samples at oversampling ticks 7, 8 and 9 of that bit. A start bit whose vote is 1 is dropped, and no flag or data changes.
- R4: While `muteActive`=1, a completed word that does not wake the block leaves `rxData` and all five flags unchanged. An idle event seen while muted never sets `idleFlag`.
- R5: While `rxEnable`=0, `rxFull`, `idleFlag`, `overrun`, `noiseFlag` and `frameErr` are 0 one cycle later. After re-enable, the block hunts for a new start bit.
- R6: `irq` = (`rxIntEn` and (`rxFull` or `overrun`)) or (`idleIntEn` and `idleFlag`).
- R7: With `wakeAddr`=1, a word whose top data bit is 1 clears `muteActive` and is delivered normally. That bit is `rxBit8` in 9-bit mode and bit 7 in 8-bit mode. A word whose top bit is 0 keeps the block muted.
- R8: With `wakeAddr`=0, a high line lasting one frame time (160 ticks in 8-bit mode, 176 in 9-bit mode) while muted clears `muteActive` and does not set `idleFlag`.
- R9: A word that completes while `rxFull`=1 sets `overrun` and leaves `rxData`, `noiseFlag` and `frameErr` unchanged.
- R10: `noiseFlag` is loaded with 1 when the three samples of any bit of the delivered frame disagree.
- R11: `frameErr` is loaded with 1 when the vote on the stop bit is 0.
- R12: After a completed word, `idleFlag` is set once the line has stayed high for one frame time in hunt state. It is not set again until another word completes.
- R13: A one-cycle `dataRead` pulse clears `rxFull`, `overrun`, `noiseFlag`, `frameErr` and `idleFlag`.
- R14: `muteSetReq` sets `muteActive` and `muteClrReq` clears it. When a clear (software or hardware) and a set fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxLine | input | 1 | Serial input line, idle high |
| rxEnable | input | 1 | Receiver enable; 0 clears flags and aborts a frame |
| wordLen9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wakeAddr | input | 1 | Wake-up method: 1 address mark, 0 idle line |
| muteSetReq | input | 1 | Pulse that enters mute mode |
| muteClrReq | input | 1 | Pulse that leaves mute mode |
| rxIntEn | input | 1 | Enables the interrupt on full or overrun |
| idleIntEn | input | 1 | Enables the interrupt on idle |
| dataRead | input | 1 | Read strobe of the data register; clears flags |
| rxData | output | 8 | Received data byte |
| rxBit8 | output | 1 | Ninth received data bit |
| rxFull | output | 1 | A word is waiting in `rxData` |
| idleFlag | output | 1 | Idle line seen after a word |
| overrun | output | 1 | A word arrived while `rxFull` was set |
| noiseFlag | output | 1 | Sample disagreement in the delivered word |
| frameErr | output | 1 | Stop bit was read as 0 |
| muteActive | output | 1 | Block is in mute mode |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that `sampleTick` is a single-cycle pulse with idle cycles between pulses. They also assume that `wordLen9` and `wakeAddr` stay constant while a frame is in progress, and that `dataRead` and the mute requests are short pulses. The bench derives the tick from a free-running divide-by-four and changes the line only on the falling clock edge after a tick. It alters word length, wake method and enables only between frames, after the stop bit has been fully driven. It also never raises a mute request in the same cycle as a frame completes, except in the one scenario that deliberately checks clear-over-set priority.

// File: rtl/rxMutePkg.sv
package rxMutePkg;

  // Strobes issued by the control unit to the datapath, one cycle each.
  typedef struct packed {
    logic capA;        // store first vote sample
    logic capB;        // store second vote sample
    logic frameStart;  // a start edge was accepted
    logic evalBit;     // third sample present, vote is valid
    logic shiftIn;     // push voted data bit into the shifter
    logic commitWord;  // deliver the assembled word
    logic raiseIdle;   // set the idle flag
    logic clearAll;    // receiver disabled
    logic readAck;     // software read of the data register
  } rxStrobe_t;

endpackage

// File: rtl/rxDatapath.sv
module rxDatapath
  import rxMutePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              wordLen9,
  input  rxStrobe_t         stb,
  output logic              bitVal,
  output logic              wordMsb,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxFull,
  output logic              idleFlag,
  output logic              overrun,
  output logic              noiseFlag,
  output logic              frameErr
);

  logic            sampA, sampB, noiseAcc, disagree;
  logic [DATA_W:0] shiftReg;

  assign bitVal   = (sampA & sampB) | (sampA & rxLine) | (sampB & rxLine);
  assign disagree = !((sampA == sampB) && (sampB == rxLine));
  assign wordMsb  = shiftReg[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA    <= 1'b1;
      sampB    <= 1'b1;
      noiseAcc <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (stb.capA) sampA <= rxLine;
      if (stb.capB) sampB <= rxLine;
      if (stb.frameStart) noiseAcc <= 1'b0;
      else if (stb.evalBit) noiseAcc <= noiseAcc | disagree;
      if (stb.shiftIn) shiftReg <= {bitVal, shiftReg[DATA_W:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxBit8    <= 1'b0;
      rxFull    <= 1'b0;
      idleFlag  <= 1'b0;
      overrun   <= 1'b0;
      noiseFlag <= 1'b0;
      frameErr  <= 1'b0;
    end else if (stb.clearAll) begin
      rxFull    <= 1'b0;
      idleFlag  <= 1'b0;
      overrun   <= 1'b0;
      noiseFlag <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      if (stb.readAck) begin
        rxFull    <= 1'b0;
        idleFlag  <= 1'b0;
        overrun   <= 1'b0;
        noiseFlag <= 1'b0;
        frameErr  <= 1'b0;
      end
      if (stb.commitWord) begin
        if (rxFull && !stb.readAck) begin
          overrun <= 1'b1;                       // old word is kept
        end else begin
          rxData    <= wordLen9 ? shiftReg[DATA_W-1:0] : shiftReg[DATA_W:1];
          rxBit8    <= wordLen9 & shiftReg[DATA_W];
          rxFull    <= 1'b1;
          noiseFlag <= noiseAcc | disagree;      // stop bit included
          frameErr  <= !bitVal;
        end
      end
      if (stb.raiseIdle) idleFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/rxControl.sv
module rxControl
  import rxMutePkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxLine,
  input  logic      rxEnable,
  input  logic      wordLen9,
  input  logic      wakeAddr,
  input  logic      muteSetReq,
  input  logic      muteClrReq,
  input  logic      dataRead,
  input  logic      bitVal,
  input  logic      wordMsb,
  output rxStrobe_t stb,
  output logic      muteActive
);

  localparam int CNT_W      = $clog2(OVERSAMPLE);
  localparam int IDX_W      = $clog2(DATA_W + 3);
  localparam int MID        = OVERSAMPLE / 2;
  localparam int IDLE_SHORT = OVERSAMPLE * (DATA_W + 2);
  localparam int IDLE_LONG  = OVERSAMPLE * (DATA_W + 3);
  localparam int IDLE_W     = $clog2(IDLE_LONG + 1);
  localparam logic [CNT_W-1:0] POS_A    = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] POS_B    = CNT_W'(MID);
  localparam logic [CNT_W-1:0] POS_VOTE = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(OVERSAMPLE - 1);

  typedef enum logic {HUNT, FRAME} rxState_e;

  rxState_e          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [IDX_W-1:0]  bitIdx, lastIdx;
  logic [IDLE_W-1:0] idleCnt, idleLimit;
  logic              muteReg, idleArm;
  logic startSeen, frameTick, voteNow, isStart, isStop, stopDone, addrWake;
  logic idleTick, idleEvent, idleWake, hwClear;

  assign lastIdx   = wordLen9 ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  assign idleLimit = wordLen9 ? IDLE_W'(IDLE_LONG) : IDLE_W'(IDLE_SHORT);
  assign isStart   = (bitIdx == '0);
  assign isStop    = (bitIdx == lastIdx);
  assign startSeen = rxEnable && state == HUNT && sampleTick && !rxLine;
  assign frameTick = rxEnable && state == FRAME && sampleTick;
  assign voteNow   = frameTick && tickCnt == POS_VOTE;
  assign stopDone  = voteNow && isStop;
  assign addrWake  = muteReg && wakeAddr && wordMsb;
  assign idleTick  = rxEnable && state == HUNT && sampleTick && rxLine;
  assign idleEvent = idleTick && (idleCnt == idleLimit - IDLE_W'(1));
  assign idleWake  = idleEvent && muteReg && !wakeAddr;
  assign hwClear   = (stopDone && addrWake) || idleWake;
  assign muteActive = muteReg;

  always_comb begin
    stb            = '0;
    stb.clearAll   = !rxEnable;
    stb.readAck    = dataRead;
    stb.frameStart = startSeen;
    stb.capA       = frameTick && tickCnt == POS_A;
    stb.capB       = frameTick && tickCnt == POS_B;
    stb.evalBit    = voteNow;
    stb.shiftIn    = voteNow && !isStart && !isStop;
    stb.commitWord = stopDone && (!muteReg || addrWake);
    stb.raiseIdle  = idleEvent && !muteReg && idleArm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= HUNT;
      tickCnt <= '0;
      bitIdx  <= '0;
      idleCnt <= '0;
      idleArm <= 1'b0;
    end else if (!rxEnable) begin
      state   <= HUNT;
      tickCnt <= '0;
      bitIdx  <= '0;
      idleCnt <= '0;
      idleArm <= 1'b0;
    end else begin
      case (state)
        HUNT: if (startSeen) begin
          state   <= FRAME;
          tickCnt <= CNT_W'(1);        // the detecting tick is sample 0
          bitIdx  <= '0;
        end
        FRAME: if (sampleTick) begin
          tickCnt <= (tickCnt == POS_LAST) ? '0 : tickCnt + CNT_W'(1);
          if (tickCnt == POS_LAST) bitIdx <= bitIdx + IDX_W'(1);
          if (voteNow && ((isStart && bitVal) || isStop)) state <= HUNT;
        end
        default: state <= HUNT;
      endcase
      if (state != HUNT || startSeen) idleCnt <= '0;
      else if (idleTick && idleCnt < idleLimit) idleCnt <= idleCnt + IDLE_W'(1);
      if (stopDone) idleArm <= 1'b1;
      else if (idleEvent) idleArm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) muteReg <= 1'b0;
    else begin
      if (muteSetReq) muteReg <= 1'b1;
      if (hwClear || muteClrReq) muteReg <= 1'b0;
    end
  end

endmodule

// File: rtl/rxMuteReceiver.sv
module rxMuteReceiver
  import rxMutePkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              rxEnable,
  input  logic              wordLen9,
  input  logic              wakeAddr,
  input  logic              muteSetReq,
  input  logic              muteClrReq,
  input  logic              rxIntEn,
  input  logic              idleIntEn,
  input  logic              dataRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              rxFull,
  output logic              idleFlag,
  output logic              overrun,
  output logic              noiseFlag,
  output logic              frameErr,
  output logic              muteActive,
  output logic              irq
);

  rxStrobe_t stb;
  logic      bitVal, wordMsb;

  rxControl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .wordLen9(wordLen9), .wakeAddr(wakeAddr),
    .muteSetReq(muteSetReq), .muteClrReq(muteClrReq), .dataRead(dataRead),
    .bitVal(bitVal), .wordMsb(wordMsb), .stb(stb), .muteActive(muteActive)
  );

  rxDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .wordLen9(wordLen9), .stb(stb),
    .bitVal(bitVal), .wordMsb(wordMsb), .rxData(rxData), .rxBit8(rxBit8),
    .rxFull(rxFull), .idleFlag(idleFlag), .overrun(overrun),
    .noiseFlag(noiseFlag), .frameErr(frameErr)
  );

  assign irq = (rxIntEn & (rxFull | overrun)) | (idleIntEn & idleFlag);

endmodule

// File: rtl/rxMuteReceiverChk.sv
module rxMuteReceiverChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              rxIntEn,
  input logic              idleIntEn,
  input logic              dataRead,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              idleFlag,
  input logic              overrun,
  input logic              noiseFlag,
  input logic              frameErr,
  input logic              muteActive,
  input logic              irq
);

  p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !(rxFull || idleFlag || overrun || noiseFlag || frameErr));

  p_full_holds_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !dataRead) |=> $stable(rxData));

  p_read_clears_overrun_r13: assert property (@(posedge clk) disable iff (!rstN)
    dataRead |=> !overrun);

  p_wake_on_delivery_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFull) && $past(muteActive)) |-> !muteActive);

  p_idle_not_muted_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> !$past(muteActive));

  p_status_needs_full_r11: assert property (@(posedge clk) disable iff (!rstN)
    (noiseFlag || frameErr || overrun) |-> rxFull);

  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idleIntEn && idleFlag) |-> irq);

  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rxIntEn && !idleIntEn) |-> !irq);

endmodule

bind rxMuteReceiver rxMuteReceiverChk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rxIntEn(rxIntEn),
  .idleIntEn(idleIntEn), .dataRead(dataRead), .rxData(rxData),
  .rxFull(rxFull), .idleFlag(idleFlag), .overrun(overrun),
  .noiseFlag(noiseFlag), .frameErr(frameErr), .muteActive(muteActive),
  .irq(irq)
);

// File: tb/test_rxMuteReceiver.sv
module test_rxMuteReceiver;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic rxLine = 1'b1, rxEnable = 1'b1, wordLen9 = 1'b0, wakeAddr = 1'b0;
  logic muteSetReq = 1'b0, muteClrReq = 1'b0;
  logic rxIntEn = 1'b0, idleIntEn = 1'b0, dataRead = 1'b0;
  logic [7:0] rxData;
  logic rxBit8, rxFull, idleFlag, overrun, noiseFlag, frameErr, muteActive, irq;
  logic [1:0] divCnt = '0;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  rxMuteReceiver i_rxMuteReceiver (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .wordLen9(wordLen9), .wakeAddr(wakeAddr),
    .muteSetReq(muteSetReq), .muteClrReq(muteClrReq), .rxIntEn(rxIntEn),
    .idleIntEn(idleIntEn), .dataRead(dataRead), .rxData(rxData),
    .rxBit8(rxBit8), .rxFull(rxFull), .idleFlag(idleFlag), .overrun(overrun),
    .noiseFlag(noiseFlag), .frameErr(frameErr), .muteActive(muteActive),
    .irq(irq)
  );

  // 16x tick: one pulse every four clocks
  initial forever begin
    @(posedge clk);
    divCnt     <= divCnt + 2'd1;
    sampleTick <= (divCnt == 2'd2);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tickWait(input int n);
    repeat (n) begin
      do @(posedge clk); while (!sampleTick);
      @(negedge clk);
    end
  endtask

  task automatic driveBit(input logic v, input int glitchAt);
    for (int t = 0; t < 16; t++) begin
      rxLine = (t == glitchAt) ? !v : v;
      tickWait(1);
    end
  endtask

  task automatic sendFrame(input logic [8:0] w, input logic nine,
                           input logic stopV, input int noiseIdx);
    driveBit(1'b0, -1);
    for (int i = 0; i < (nine ? 9 : 8); i++) driveBit(w[i], (i == noiseIdx) ? 8 : -1);
    driveBit(stopV, -1);
    rxLine = 1'b1;
  endtask

  task automatic pulseRead;
    @(negedge clk) dataRead = 1'b1;
    @(negedge clk) dataRead = 1'b0;
  endtask

  task automatic pulseMute(input logic setIt, input logic clrIt);
    @(negedge clk) begin muteSetReq = setIt; muteClrReq = clrIt; end
    @(negedge clk) begin muteSetReq = 1'b0; muteClrReq = 1'b0; end
  endtask

  task automatic tReset;
    chk("R5 reset rxFull", rxFull, 0);
    chk("R5 reset flags", {idleFlag, overrun, noiseFlag, frameErr}, 0);
    chk("R14 reset mute", muteActive, 0);
    chk("R6 reset irq", irq, 0);
  endtask

  task automatic tBasic8;
    rxIntEn = 1'b1;
    sendFrame(9'h0A5, 1'b0, 1'b1, -1);
    chk("R1 data 8-bit", rxData, 8'hA5);
    chk("R1 rxFull", rxFull, 1);
    chk("R2 bit8 zero in 8-bit", rxBit8, 0);
    chk("R11 no frame error", frameErr, 0);
    chk("R10 no noise", noiseFlag, 0);
    chk("R6 irq on full", irq, 1);
    pulseRead();
    chk("R13 read clears full", rxFull, 0);
    chk("R6 irq low after read", irq, 0);
  endtask

  task automatic tNine;
    wordLen9 = 1'b1;
    sendFrame(9'h13C, 1'b1, 1'b1, -1);
    chk("R2 data 9-bit", rxData, 8'h3C);
    chk("R2 ninth bit one", rxBit8, 1);
    pulseRead();
    sendFrame(9'h0C3, 1'b1, 1'b1, -1);
    chk("R2 data 9-bit second", rxData, 8'hC3);
    chk("R2 ninth bit zero", rxBit8, 0);
    pulseRead();
    wordLen9 = 1'b0;
  endtask

  task automatic tOverrun;
    sendFrame(9'h011, 1'b0, 1'b1, -1);
    sendFrame(9'h022, 1'b0, 1'b1, 2);
    chk("R9 overrun set", overrun, 1);
    chk("R9 old data kept", rxData, 8'h11);
    chk("R9 noise untouched", noiseFlag, 0);
    chk("R6 irq on overrun", irq, 1);
    pulseRead();
    chk("R13 read clears overrun", overrun, 0);
  endtask

  task automatic tNoise;
    sendFrame(9'h05A, 1'b0, 1'b1, 3);
    chk("R10 noise set", noiseFlag, 1);
    chk("R3 majority keeps data", rxData, 8'h5A);
    pulseRead();
    chk("R13 read clears noise", noiseFlag, 0);
  endtask

  task automatic tFrameErr;
    sendFrame(9'h03C, 1'b0, 1'b0, -1);
    tickWait(40);
    chk("R11 frame error", frameErr, 1);
    chk("R11 data still given", rxData, 8'h3C);
    pulseRead();
    chk("R13 read clears frame error", frameErr, 0);
  endtask

  task automatic tFalseStart;
    rxLine = 1'b0;
    tickWait(4);
    rxLine = 1'b1;
    tickWait(40);
    chk("R3 false start ignored", rxFull, 0);
  endtask

  task automatic tIdle;
    rxIntEn = 1'b0;
    idleIntEn = 1'b1;
    tickWait(200);
    pulseRead();
    sendFrame(9'h077, 1'b0, 1'b1, -1);
    pulseRead();
    tickWait(150);
    chk("R12 idle not yet", idleFlag, 0);
    tickWait(10);
    chk("R12 idle after frame time", idleFlag, 1);
    chk("R6 irq on idle", irq, 1);
    pulseRead();
    chk("R13 read clears idle", idleFlag, 0);
    tickWait(200);
    chk("R12 idle only once", idleFlag, 0);
    idleIntEn = 1'b0;
  endtask

  task automatic tAddrWake;
    wakeAddr = 1'b1;
    pulseMute(1'b1, 1'b0);
    chk("R14 set mute", muteActive, 1);
    sendFrame(9'h012, 1'b0, 1'b1, -1);
    chk("R4 muted word dropped", rxFull, 0);
    chk("R7 msb zero keeps mute", muteActive, 1);
    sendFrame(9'h085, 1'b0, 1'b1, -1);
    chk("R7 msb one wakes", muteActive, 0);
    chk("R7 waking word delivered", rxData, 8'h85);
    pulseRead();
    wordLen9 = 1'b1;
    pulseMute(1'b1, 1'b0);
    sendFrame(9'h0FF, 1'b1, 1'b1, -1);
    chk("R7 9-bit bit8 zero keeps mute", muteActive, 1);
    chk("R4 9-bit muted word dropped", rxFull, 0);
    sendFrame(9'h101, 1'b1, 1'b1, -1);
    chk("R7 9-bit bit8 one wakes", muteActive, 0);
    chk("R7 9-bit ninth bit", rxBit8, 1);
    pulseRead();
    wordLen9 = 1'b0;
  endtask

  task automatic tIdleWake;
    wakeAddr = 1'b0;
    tickWait(200);
    pulseRead();
    pulseMute(1'b1, 1'b0);
    sendFrame(9'h085, 1'b0, 1'b1, -1);
    chk("R4 idle mode ignores address", muteActive, 1);
    chk("R4 muted word not full", rxFull, 0);
    tickWait(150);
    chk("R8 still muted before frame time", muteActive, 1);
    tickWait(10);
    chk("R8 idle wake clears mute", muteActive, 0);
    chk("R8 no idle flag on wake", idleFlag, 0);
  endtask

  task automatic tDisable;
    sendFrame(9'h03C, 1'b0, 1'b1, -1);
    sendFrame(9'h044, 1'b0, 1'b1, -1);
    chk("R9 overrun before disable", overrun, 1);
    @(negedge clk) rxEnable = 1'b0;
    @(negedge clk) rxEnable = 1'b1;
    chk("R5 disable clears full", rxFull, 0);
    chk("R5 disable clears overrun", overrun, 0);
    sendFrame(9'h0E1, 1'b0, 1'b1, -1);
    chk("R5 receives after re-enable", rxData, 8'hE1);
    pulseRead();
  endtask

  task automatic tSwMute;
    pulseMute(1'b1, 1'b0);
    chk("R14 software set", muteActive, 1);
    pulseMute(1'b0, 1'b1);
    chk("R14 software clear", muteActive, 0);
    pulseMute(1'b1, 1'b1);
    chk("R14 clear wins over set", muteActive, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic8();
    tNine();
    tOverrun();
    tNoise();
    tFrameErr();
    tFalseStart();
    tIdle();
    tAddrWake();
    tIdleWake();
    tDisable();
    tSwMute();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule